// File: doc/BRIEF.md
# Bus Master Tenure Latency Counter

This block decides when a bus master must give up the bus after the arbiter withdraws its grant. At the start of a tenure, the programmed latency value is captured into a down-counter. The start of a tenure is the first cycle in which the frame line is asserted while this master is the one driving a transfer. The counter then runs down by one on every clock. It saturates at zero.

While the counter is still running, losing the grant changes nothing, and the master carries on with its burst. Once the counter has run out and the grant is absent, the block raises a registered release request. The master state machine uses it to finish the current burst. The request stays up until the frame line drops.

Whenever the frame line is inactive, the counter is cleared and held. Single-phase transactions are therefore never affected. Arbitration and data-phase sequencing belong to other blocks.

Top module: `lat_tenure_ctr`

## Requirements
- R1: While `rst` is high, and after any clock edge at which `rst` was high, `release_req` is 0 and the counter is cleared.
- R2: A tenure starts at the first rising clock edge at which `frame_act` and `xfer_act` are both 1 after a cycle in which either was 0. At that edge the `lat_val` value is captured. Every later tenure captures the value afresh.
- R3: The counter moves down by one per clock. Counting the starting edge as edge 0, the count is expired at edge `lat_val` and at every later edge of the same tenure.
- R4: The counter saturates at zero and never wraps. A tenure with `lat_val` = 255 expires at edge 255 and stays expired.
- R5: When `gnt_act` is 0 at an edge before expiry, `release_req` stays 0 and the tenure continues.
- R6: At the first edge where the count is expired and `gnt_act` is 0, `release_req` becomes 1, visible right after that edge. It stays 1 while `frame_act` and `xfer_act` remain 1.
- R7: At any edge where `frame_act` is 0, the counter is cleared and `release_req` becomes 0 after that edge.
- R8: With `lat_val` = 0, `release_req` rises after the first edge of the tenure at which `gnt_act` is 0, including edge 0.
- R9: If `gnt_act` returns to 1 before expiry and is 1 at every edge from expiry on, no release is requested during that tenure.
- R10: When `xfer_act` is 0, no tenure runs: the frame line alone neither loads the counter nor raises `release_req`.
- R11: Changes on `lat_val` after the starting edge have no effect on the tenure in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| frame_act | input | 1 | Frame line asserted (active-high view) |
| gnt_act | input | 1 | Grant to this master present (active-high view) |
| xfer_act | input | 1 | This master is driving the current transfer |
| lat_val | input | CNT_W (8) | Programmed latency value in clocks |
| release_req | output | 1 | Registered request to end the current burst |

## Verification
Several properties are checked on every cycle:
- An idle frame line or an idle transfer indication always clears the request on the next edge, and an idle frame line also clears the counter.
- A rising request is always preceded by an expired count with the grant absent.
- A running count only steps down by one or clears.
- An expired count never climbs back up.
- The request stays set through an ongoing tenure.

Only the bench's scenarios can show the exact edge of expiry for a given latency value. The same holds for the effect of a grant that comes back before expiry, for a fresh load on every new tenure, and for ignoring latency changes made mid-tenure.

// File: rtl/lt_pkg.sv
package lt_pkg;

    // Ownership view derived from the bus lines
    typedef struct packed {
        logic own;    // this master holds an active frame
        logic start;  // first cycle of that frame
    } tenure_t;

    // Release request state
    typedef enum logic {
        REL_HOLD = 1'b0,
        REL_ASK  = 1'b1
    } rel_e;

endpackage

// File: rtl/lt_tenure_detect.sv
module lt_tenure_detect
    import lt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_act,
    input  logic    xfer_act,
    output tenure_t ten
);
    logic own_q;
    logic own_now;

    assign own_now = frame_act & xfer_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= 1'b0;
        end else begin
            own_q <= own_now;
        end
    end

    always_comb begin
        ten.own   = own_now;
        ten.start = own_now & ~own_q;
    end
endmodule

// File: rtl/lt_down_counter.sv
module lt_down_counter
    import lt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tenure_t          ten,
    input  logic [CNT_W-1:0] lat_val,
    output logic [CNT_W-1:0] count_q,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] load_val;

    // The starting cycle already consumes one clock of the budget
    assign load_val = (lat_val == ZERO) ? ZERO : (lat_val - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= ZERO;
        end else if (!ten.own) begin
            count_q <= ZERO;
        end else if (ten.start) begin
            count_q <= load_val;
        end else if (count_q != ZERO) begin
            count_q <= count_q - ONE;
        end
    end

    always_comb begin
        if (!ten.own) begin
            expired = 1'b0;
        end else if (ten.start) begin
            expired = (lat_val == ZERO);
        end else begin
            expired = (count_q == ZERO);
        end
    end
endmodule

// File: rtl/lt_release_reg.sv
module lt_release_reg
    import lt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tenure_t ten,
    input  logic    expired,
    input  logic    gnt_act,
    output logic    release_req
);
    rel_e state_q;
    rel_e state_d;

    always_comb begin
        state_d = REL_HOLD;
        if (ten.own) begin
            if (state_q == REL_ASK) begin
                state_d = REL_ASK;
            end else if (expired && !gnt_act) begin
                state_d = REL_ASK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= REL_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    assign release_req = (state_q == REL_ASK);
endmodule

// File: rtl/lat_tenure_ctr.sv
module lat_tenure_ctr
    import lt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_act,
    input  logic             gnt_act,
    input  logic             xfer_act,
    input  logic [CNT_W-1:0] lat_val,
    output logic             release_req
);
    tenure_t          ten;
    logic [CNT_W-1:0] count_q;
    logic             expired;

    lt_tenure_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .frame_act (frame_act),
        .xfer_act  (xfer_act),
        .ten       (ten)
    );

    lt_down_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .ten     (ten),
        .lat_val (lat_val),
        .count_q (count_q),
        .expired (expired)
    );

    lt_release_reg u_release (
        .clk         (clk),
        .rst         (rst),
        .ten         (ten),
        .expired     (expired),
        .gnt_act     (gnt_act),
        .release_req (release_req)
    );
endmodule

// File: rtl/lat_tenure_ctr_chk.sv
module lat_tenure_ctr_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_act,
    input logic             gnt_act,
    input logic             xfer_act,
    input logic             release_req,
    input logic             ten_own,
    input logic             ten_start,
    input logic             expired,
    input logic [CNT_W-1:0] count_q
);
    // R7
    frame_low_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_act |=> (!release_req && count_q == '0));

    // R10
    xfer_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_act |=> !release_req);

    // R6
    release_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(release_req) |-> $past(expired && !gnt_act));

    // R6
    release_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (release_req && frame_act && xfer_act) |=> release_req);

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ten_own && !ten_start && count_q == '0) |=> count_q == '0);

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (ten_own && !ten_start && count_q != '0) |=>
            (count_q == CNT_W'($past(count_q) - CNT_W'(1)) || count_q == '0));
endmodule

bind lat_tenure_ctr lat_tenure_ctr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_act   (frame_act),
    .gnt_act     (gnt_act),
    .xfer_act    (xfer_act),
    .release_req (release_req),
    .ten_own     (ten.own),
    .ten_start   (ten.start),
    .expired     (expired),
    .count_q     (count_q)
);

// File: tb/lat_tenure_ctr_tb.sv
module lat_tenure_ctr_tb;
    localparam int  CNT_W   = 8;
    localparam time CLK_P   = 20ns;
    localparam int  NV      = 8;
    localparam int  WD_CYC  = 200000;

    // Scenario table: latency, grant drop edge, grant return edge,
    // transfer flag, length in edges, expected first release edge (-1 none)
    localparam int V_LAT [NV] = '{4, 0, 5, 2, 3, 0, 255, 1};
    localparam int V_DROP[NV] = '{2, 3, 1, 0, 6, 0, 0,   0};
    localparam int V_BACK[NV] = '{999, 999, 3, 999, 999, 999, 999, 1};
    localparam int V_XFER[NV] = '{1, 1, 1, 1, 1, 0, 1, 1};
    localparam int V_LEN [NV] = '{8, 6, 10, 5, 9, 5, 258, 5};
    localparam int V_EXP [NV] = '{4, 3, -1, 2, 6, -1, 255, -1};

    logic             clk = 1'b0;
    logic             rst;
    logic             frame_act;
    logic             gnt_act;
    logic             xfer_act;
    logic [CNT_W-1:0] lat_val;
    logic             release_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lat_tenure_ctr #(.CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .frame_act   (frame_act),
        .gnt_act     (gnt_act),
        .xfer_act    (xfer_act),
        .lat_val     (lat_val),
        .release_req (release_req)
    );

    function automatic string req_of(input int v);
        case (v)
            0: return "R5";
            1: return "R8";
            2: return "R9";
            3: return "R3";
            4: return "R4";
            5: return "R10";
            6: return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: release_req=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        frame_act = 1'b0;
        gnt_act   = 1'b1;
        step();
        check(req, release_req, 1'b0);
    endtask

    initial begin
        #(CLK_P * WD_CYC);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; frame_act = 1'b0; gnt_act = 1'b1; xfer_act = 1'b1; lat_val = '0;
        repeat (3) step();
        // R1 reset state
        check("R1", release_req, 1'b0);
        @(negedge clk); rst = 1'b0;
        step();
        check("R1", release_req, 1'b0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < V_LEN[v]; i++) begin
                @(negedge clk);
                frame_act = 1'b1;
                xfer_act  = V_XFER[v][0];
                lat_val   = (i == 0) ? CNT_W'(V_LAT[v]) : lat_val;
                gnt_act   = !(i >= V_DROP[v] && i < V_BACK[v]);
                step();
                check(req_of(v), release_req, (V_EXP[v] >= 0 && i >= V_EXP[v]));
            end
            // R7 frame idle clears request
            idle_check("R7");
            idle_check("R7");
            xfer_act = 1'b1;
        end

        // R11: latency changed mid-tenure is ignored
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            frame_act = 1'b1;
            gnt_act   = 1'b0;
            lat_val   = (i == 0) ? CNT_W'(2) : CNT_W'(200);
            step();
            check("R11", release_req, (i >= 2));
        end
        // R7 single idle cycle, then R2 fresh load on the next tenure
        idle_check("R7");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            frame_act = 1'b1;
            gnt_act   = 1'b0;
            lat_val   = CNT_W'(3);
            step();
            check("R2", release_req, (i >= 3));
        end

        // R1 reset in the middle of a requesting tenure
        @(negedge clk);
        rst = 1'b1;
        step();
        check("R1", release_req, 1'b0);
        @(negedge clk);
        rst = 1'b0; frame_act = 1'b0; gnt_act = 1'b1;
        step();
        check("R1", release_req, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule